// File: doc/BRIEF.md
# Real-Time Clock with Deferred Register Commit

This peripheral keeps wall-clock time as a whole-seconds word and a sub-second fraction. The fraction advances on each `tick_en` pulse and rolls over into the seconds word. A two-word alarm compare raises a sticky flag when the running time equals it. An interrupt output is driven from the status flags that software has enabled.

Software reaches the block through a plain 32-bit register port. A write does not update its target at once. It is captured and held for a fixed number of cycles, and then committed. The outcome is reported in status: a busy flag while the write is pending, then either a complete/next pair or an error flag. The bus has no back-pressure pin. A write presented while another is pending is discarded and flagged as an error, so the busy and complete flags are the only flow control. Software waits for complete or error after each write.

At reset the block is marked not-valid. In that state it rejects every write except a write to status. The time counter also stays frozen until its seconds word has been written at least once, even when counting is enabled.

Top module: `rtc_secure`

## Requirements
- R1: After reset the status word reads 0x002 (only not-valid set), the seconds and fraction words read 0, the alarm-seconds word reads 0xFFFFFFFF, the control and interrupt-enable words read 0, and `irq` is low.
- R2: A write accepted at one clock edge keeps status bit 10 (busy) at 1 for exactly COMMIT_LAT cycles. During that time the target keeps its old value. At the commit edge the target takes the new value, busy falls, and bit 8 (complete) and bit 9 (next) rise.
- R3: A write presented while busy is discarded and sets status bit 7 (error) at that same edge. The pending write still commits with its own data.
- R4: While status bit 1 (not-valid) is 1, a committed write to any word other than status is not applied. It sets bit 7 and leaves bit 8 at 0.
- R5: Status bits 7, 4, 1 and 0 clear only when a 1 is written to their position. Writing 0 leaves them unchanged. Bits 8 and 9 clear when the next write is accepted.
- R6: The fraction and seconds words do not advance on ticks until the seconds word has been written once since reset, even with control bit 3 (run) set.
- R7: With run set and seconds written, each cycle with `tick_en` high adds 1 to the fraction. From FRAC_MOD-1 the fraction goes to 0 and the seconds word adds 1. With run clear, ticks have no effect.
- R8: Status bit 4 (alarm) is set one cycle after the seconds and fraction words equal the alarm-seconds and alarm-fraction words, and it stays set after they differ. It is never set while alarm-seconds is 0xFFFFFFFF.
- R9: `irq` is high exactly when some bit among 9, 8, 7 and 4 is 1 in both status and interrupt-enable. The interrupt-enable word stores only those four bits.
- R10: Word offsets are 0x00 seconds, 0x04 fraction, 0x08 alarm seconds, 0x0C alarm fraction, 0x10 control, 0x14 status and 0x18 interrupt enable. Reads return the current value combinationally from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Fraction advance strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write request, one write per high cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with COMMIT_LAT at 4 and FRAC_MOD at 8. With a modulus of 8, a fraction rollover into the seconds word takes only a few ticks. An alarm match in the following second is also reachable in a handful of cycles, and the not-valid, rejected-write, overlapping-write and sticky-alarm paths all fit in short directed sequences. The four-cycle commit window is long enough to count busy cycle by cycle and to land a second write inside it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFS_SEC   = 'h00;
  localparam int OFS_FRAC  = 'h04;
  localparam int OFS_ASEC  = 'h08;
  localparam int OFS_AFRAC = 'h0C;
  localparam int OFS_CTRL  = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_IER   = 'h18;

  localparam int CTRL_RUN  = 3;

  localparam int ST_BUSY = 10;
  localparam int ST_NEXT = 9;
  localparam int ST_DONE = 8;
  localparam int ST_ERR  = 7;
  localparam int ST_ALM  = 4;
  localparam int ST_NV   = 1;
  localparam int ST_SV   = 0;

  typedef enum logic [2:0] {
    SEL_SEC, SEL_FRAC, SEL_ASEC, SEL_AFRAC, SEL_CTRL, SEL_STAT, SEL_IER, SEL_NONE
  } reg_sel_e;

  // W1C request bits in the order {err, alarm, not-valid, violation}
  typedef struct packed {
    logic err;
    logic alm;
    logic nv;
    logic sv;
  } w1c_t;
endpackage

// File: rtl/rtc_wr_engine.sv
module rtc_wr_engine
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int COMMIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              accept,
  output logic              drop,
  output logic              commit,
  output reg_sel_e          pend_sel,
  output logic [DATA_W-1:0] pend_data
);
  localparam int CNT_W = (COMMIT_LAT > 1) ? $clog2(COMMIT_LAT) : 1;

  logic [CNT_W-1:0] cnt_q;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFS_SEC))        return SEL_SEC;
    else if (a == ADDR_W'(OFS_FRAC))  return SEL_FRAC;
    else if (a == ADDR_W'(OFS_ASEC))  return SEL_ASEC;
    else if (a == ADDR_W'(OFS_AFRAC)) return SEL_AFRAC;
    else if (a == ADDR_W'(OFS_CTRL))  return SEL_CTRL;
    else if (a == ADDR_W'(OFS_STAT))  return SEL_STAT;
    else if (a == ADDR_W'(OFS_IER))   return SEL_IER;
    else                              return SEL_NONE;
  endfunction

  assign accept = wr_en && !busy;
  assign drop   = wr_en && busy;
  assign commit = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      pend_sel  <= SEL_NONE;
      pend_data <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      cnt_q     <= CNT_W'(COMMIT_LAT - 1);
      pend_sel  <= decode(addr);
      pend_data <= wdata;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: an accepted write makes the engine busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R2: the commit edge frees the engine
  a_r2_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  // R3: a dropped write leaves the captured data alone
  a_r3_drop_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !commit) |=> $stable(pend_data));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int DATA_W = 32,
  parameter int FRAC_MOD = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              sec_we,
  input  logic              frac_we,
  input  logic              asec_we,
  input  logic              afrac_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sec,
  output logic [DATA_W-1:0] frac,
  output logic [DATA_W-1:0] alm_sec,
  output logic [DATA_W-1:0] alm_frac,
  output logic              match
);
  localparam logic [DATA_W-1:0] FRAC_TOP = DATA_W'(FRAC_MOD - 1);

  logic started_q;
  logic count_en;
  logic wrap;

  assign count_en = run && started_q && tick;
  assign wrap     = (frac >= FRAC_TOP);
  assign match    = (sec == alm_sec) && (frac == alm_frac) && (alm_sec != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec       <= '0;
      frac      <= '0;
      started_q <= 1'b0;
    end else begin
      if (sec_we) begin
        sec       <= wdata;
        started_q <= 1'b1;
      end else if (count_en && wrap) begin
        sec <= sec + 1'b1;
      end
      if (frac_we)       frac <= wdata;
      else if (count_en) frac <= wrap ? '0 : frac + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_sec  <= '1;
      alm_frac <= '0;
    end else begin
      if (asec_we)  alm_sec  <= wdata;
      if (afrac_we) alm_frac <= wdata;
    end
  end

  // R6: no advance before the seconds word has been set
  a_r6_frozen_until_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!started_q && !frac_we) |=> (frac == $past(frac)));
  // R7: rollover carries into seconds
  a_r7_wrap_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && wrap && !sec_we) |=> (sec == $past(sec) + 1'b1));
  // R7: rollover returns the fraction to zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && wrap && !frac_we) |=> (frac == '0));
endmodule

// File: rtl/rtc_stat_irq.sv
module rtc_stat_irq
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              accept,
  input  logic              drop,
  input  logic              commit_ok,
  input  logic              commit_err,
  input  logic              stat_we,
  input  w1c_t              w1c,
  input  logic              ier_we,
  input  logic [DATA_W-1:0] ier_data,
  input  logic              alarm_match,
  output logic              nv,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] ier,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IRQ_MASK =
    (DATA_W'(1) << ST_NEXT) | (DATA_W'(1) << ST_DONE) |
    (DATA_W'(1) << ST_ERR)  | (DATA_W'(1) << ST_ALM);

  logic next_q, done_q, err_q, alm_q, sv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      alm_q  <= 1'b0;
      nv     <= 1'b1;
      sv_q   <= 1'b0;
      ier    <= '0;
    end else begin
      if (commit_ok) begin
        next_q <= 1'b1;
        done_q <= 1'b1;
      end else if (accept) begin
        next_q <= 1'b0;
        done_q <= 1'b0;
      end
      if (drop || commit_err)   err_q <= 1'b1;
      else if (stat_we && w1c.err) err_q <= 1'b0;
      if (alarm_match)          alm_q <= 1'b1;
      else if (stat_we && w1c.alm) alm_q <= 1'b0;
      if (stat_we && w1c.nv) nv   <= 1'b0;
      if (stat_we && w1c.sv) sv_q <= 1'b0;
      if (ier_we) ier <= ier_data & IRQ_MASK;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_NEXT] = next_q;
    status[ST_DONE] = done_q;
    status[ST_ERR]  = err_q;
    status[ST_ALM]  = alm_q;
    status[ST_NV]   = nv;
    status[ST_SV]   = sv_q;
  end

  assign irq = |(status & ier & IRQ_MASK);

  // R3: a dropped write raises the error flag
  a_r3_drop_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err_q);
  // R5: writing 0 to status leaves the error flag set
  a_r5_zero_keeps_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(stat_we && w1c.err)) |=> err_q);
  // R8: the alarm flag is sticky
  a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q && !(stat_we && w1c.alm)) |=> alm_q);
endmodule

// File: rtl/rtc_secure.sv
module rtc_secure
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int COMMIT_LAT = 4,
  parameter int FRAC_MOD = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              busy, accept, drop, commit;
  reg_sel_e          pend_sel;
  logic [DATA_W-1:0] pend_data;
  logic              nv, commit_ok, commit_err;
  logic              run_q;
  logic [DATA_W-1:0] sec, frac, alm_sec, alm_frac, status, ier;
  logic              match;
  w1c_t              w1c;

  rtc_wr_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMMIT_LAT(COMMIT_LAT)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .accept(accept), .drop(drop), .commit(commit),
    .pend_sel(pend_sel), .pend_data(pend_data)
  );

  assign commit_ok  = commit && (!nv || pend_sel == SEL_STAT);
  assign commit_err = commit && !commit_ok;

  assign w1c.err = pend_data[ST_ERR];
  assign w1c.alm = pend_data[ST_ALM];
  assign w1c.nv  = pend_data[ST_NV];
  assign w1c.sv  = pend_data[ST_SV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 run_q <= 1'b0;
    else if (commit_ok && pend_sel == SEL_CTRL) run_q <= pend_data[CTRL_RUN];
  end

  rtc_time_core #(.DATA_W(DATA_W), .FRAC_MOD(FRAC_MOD)) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .run(run_q),
    .sec_we(commit_ok && pend_sel == SEL_SEC),
    .frac_we(commit_ok && pend_sel == SEL_FRAC),
    .asec_we(commit_ok && pend_sel == SEL_ASEC),
    .afrac_we(commit_ok && pend_sel == SEL_AFRAC),
    .wdata(pend_data), .sec(sec), .frac(frac),
    .alm_sec(alm_sec), .alm_frac(alm_frac), .match(match)
  );

  rtc_stat_irq #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .drop(drop),
    .commit_ok(commit_ok), .commit_err(commit_err),
    .stat_we(commit_ok && pend_sel == SEL_STAT), .w1c(w1c),
    .ier_we(commit_ok && pend_sel == SEL_IER), .ier_data(pend_data),
    .alarm_match(match), .nv(nv), .status(status), .ier(ier), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_SEC))        bus_rdata = sec;
    else if (bus_addr == ADDR_W'(OFS_FRAC))  bus_rdata = frac;
    else if (bus_addr == ADDR_W'(OFS_ASEC))  bus_rdata = alm_sec;
    else if (bus_addr == ADDR_W'(OFS_AFRAC)) bus_rdata = alm_frac;
    else if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata[CTRL_RUN] = run_q;
    else if (bus_addr == ADDR_W'(OFS_STAT))  bus_rdata = status;
    else if (bus_addr == ADDR_W'(OFS_IER))   bus_rdata = ier;
  end

  // R4: a rejected write reports error without complete
  a_r4_reject_reports_err: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && nv && pend_sel != SEL_STAT) |=> (status[ST_ERR] && !status[ST_DONE]));
  // R4: a rejected write does not touch the seconds word
  a_r4_reject_no_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && nv && pend_sel == SEL_SEC && !tick_en) |=> $stable(sec));
endmodule

// File: tb/test_rtc_secure.sv
module test_rtc_secure;
  localparam int LAT = 4;
  localparam int FMOD = 8;
  localparam logic [4:0] A_SEC = 5'h00, A_FRAC = 5'h04, A_ASEC = 5'h08,
                         A_AFRAC = 5'h0C, A_CTRL = 5'h10, A_STAT = 5'h14, A_IER = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_secure #(.ADDR_W(5), .DATA_W(32), .COMMIT_LAT(LAT), .FRAC_MOD(FMOD)) i_rtc_secure (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic check_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // issue a write; returns at the falling edge just after the accepting edge
  task automatic issue(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    issue(a, d);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    check_reg("R1 status", A_STAT, 32'h002);
    check_reg("R1 seconds", A_SEC, 32'h0);
    check_reg("R1 fraction", A_FRAC, 32'h0);
    check_reg("R1 alarm seconds", A_ASEC, 32'hFFFF_FFFF);
    check_reg("R1 control", A_CTRL, 32'h0);
    check_reg("R1 ier", A_IER, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_not_valid;
    wr(A_CTRL, 32'h8);
    check_reg("R4 status after rejected write", A_STAT, 32'h082);
    check_reg("R4 control untouched", A_CTRL, 32'h0);
    wr(A_STAT, 32'h082);
    check_reg("R5 clear err and not-valid", A_STAT, 32'h300);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    issue(A_AFRAC, 32'h3);
    for (int i = 0; i < LAT; i++) begin
      rd(A_STAT, v);
      check("R2 busy during pending", v, 32'h400);  // R5: done/next cleared on accept
      check_reg("R2 target unchanged", A_AFRAC, 32'h0);
      @(negedge clk);
    end
    check_reg("R2 status after commit", A_STAT, 32'h300);
    check_reg("R2 R10 alarm fraction at 0x0C", A_AFRAC, 32'h3);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    bus_addr = A_AFRAC; bus_wdata = 32'h5; bus_we = 1'b1;
    @(negedge clk);
    bus_wdata = 32'h7;
    @(negedge clk);
    bus_we = 1'b0;
    check_reg("R3 error at dropped write", A_STAT, 32'h480);
    repeat (LAT - 1) @(negedge clk);
    check_reg("R3 first write committed", A_AFRAC, 32'h5);
    check_reg("R3 status after commit", A_STAT, 32'h380);
    wr(A_STAT, 32'h0);
    check_reg("R5 zero write keeps error", A_STAT, 32'h380);
    wr(A_STAT, 32'h80);
    check_reg("R5 one clears error", A_STAT, 32'h300);
  endtask

  task automatic t_frozen;
    wr(A_CTRL, 32'h8);
    check_reg("R10 control run bit", A_CTRL, 32'h8);
    ticks(5);
    check_reg("R6 fraction frozen", A_FRAC, 32'h0);
    check_reg("R6 seconds frozen", A_SEC, 32'h0);
  endtask

  task automatic t_count;
    wr(A_SEC, 32'h5);
    ticks(3);
    check_reg("R7 fraction counts", A_FRAC, 32'h3);
    check_reg("R7 seconds held", A_SEC, 32'h5);
    ticks(5);
    check_reg("R7 fraction wraps", A_FRAC, 32'h0);
    check_reg("R7 seconds carry", A_SEC, 32'h6);
    wr(A_CTRL, 32'h0);
    ticks(4);
    check_reg("R7 run clear stops fraction", A_FRAC, 32'h0);
    check_reg("R7 run clear stops seconds", A_SEC, 32'h6);
    wr(A_CTRL, 32'h8);
  endtask

  task automatic t_alarm;
    logic [31:0] v;
    wr(A_SEC, 32'hFFFF_FFFF);
    wr(A_FRAC, 32'h5);
    @(negedge clk);
    rd(A_STAT, v);
    check("R8 disabled alarm never fires", v & 32'h10, 32'h0);
    wr(A_SEC, 32'h6);
    wr(A_FRAC, 32'h0);
    wr(A_AFRAC, 32'h4);
    wr(A_ASEC, 32'h6);
    ticks(3);
    rd(A_STAT, v);
    check("R8 no flag before match", v & 32'h10, 32'h0);
    ticks(1);
    rd(A_STAT, v);
    check("R8 flag not yet at match cycle", v & 32'h10, 32'h0);
    @(negedge clk);
    rd(A_STAT, v);
    check("R8 flag one cycle after match", v & 32'h10, 32'h10);
    ticks(1);
    rd(A_STAT, v);
    check("R8 flag sticky", v & 32'h10, 32'h10);
  endtask

  task automatic t_irq;
    check("R9 irq low with nothing enabled", {31'b0, irq}, 32'h0);
    wr(A_IER, 32'h10);
    check("R9 irq from alarm", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h10);
    check_reg("R5 alarm cleared", A_STAT, 32'h300);
    check("R9 irq drops with alarm", {31'b0, irq}, 32'h0);
    wr(A_IER, 32'hFFFF_FFFF);
    check_reg("R9 ier keeps only bits 9 8 7 4", A_IER, 32'h390);
    check("R9 irq from complete", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_not_valid;
    t_latency;
    t_overlap;
    t_frozen;
    t_count;
    t_alarm;
    t_irq;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule